// File: doc/BRIEF.md
# Upward-Growing Stack Sequencer

This block carries out the subroutine and stack instructions of a 16-bit processor that has sixteen general registers. Decode, fetch and condition evaluation happen outside it. The block receives one already-decoded operation at a time on a valid/ready command port. It then runs the memory transfers that the operation needs, one 16-bit word per beat, through a request/ready data-memory port. It keeps the stack pointer itself. When an operation ends, it produces the new program counter, register-file writes or a restored flags word. The stack grows toward higher addresses. A push writes at the stack pointer and then adds 2. A pop first subtracts 2 and then reads.

Back-pressure on the command port works as follows. `cmd_ready` is high only while no operation is in flight. An operation is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. The issuer keeps `cmd_valid` and all command fields steady until that cycle. On the memory side the block raises `mem_req` and holds address, direction and write data unchanged. A beat completes in each cycle where `mem_req` and `mem_ready` are both high. Memory words are little-endian, with the low byte at the even address. The register file is read combinationally through `rf_raddr`/`rf_rdata`.

Top module: `stack_seq`

## Requirements
- R1: After reset the stack pointer is 0, `cmd_ready` is 1, and `mem_req` and `done` are 0.
- R2: Op code 0 loads the stack pointer with `cmd_imm`. It makes no memory access, and `done` is high in its acceptance cycle.
- R3: Op code 1 (target `cmd_imm`) and op code 2 (target = register `cmd_reg`) write `cmd_pc`+4 to the word at SP and add 2 to SP. In the cycle of that write beat they raise `pc_we` with `pc_out` equal to the target.
- R4: Op code 3 subtracts 2 from SP, reads the word at the new SP, and presents it on `pc_out` with `pc_we` in that read beat.
- R5: Op code 4 writes register `cmd_reg` to the word at SP and then adds 2 to SP. Op code 5 subtracts 2 from SP, reads that word and writes it to register `cmd_reg`.
- R6: Op code 6 pushes `flags_in` and op code 7 pops one word onto `flags_out` with `flags_we`. Both use the same 2-byte step as R5.
- R7: Op code 8 writes registers 0 through 15 in ascending order to addresses SP, SP+2, …, SP+30, then adds 32 to SP.
- R8: Op code 9 subtracts 32 from SP, then reads ascending addresses from the new SP and writes register i from the word at SP+2i.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.
- R10: `cmd_ready` is low while an operation is in flight. A command held on `cmd_valid` during that time is taken only once the block is idle again.
- R11: `done` is high for exactly the cycle of the final beat of a memory operation. `rf_we`, `pc_we` and `flags_we` are high only in beat cycles.
- R12: All SP arithmetic, and the addresses made from it, wrap modulo 2^16.
- R13: Op codes 10 to 15 are accepted with `done` in the acceptance cycle. They make no memory access and leave SP unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_op | input | 4 | Decoded operation code |
| cmd_reg | input | 4 | Register operand |
| cmd_imm | input | 16 | Immediate (call target or new SP) |
| cmd_pc | input | 16 | Address of the current instruction |
| flags_in | input | 16 | Current flags word |
| rf_raddr | output | 4 | Register-file read address |
| rf_rdata | input | 16 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 4 | Register-file write address |
| rf_wdata | output | 16 | Register-file write data |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write word |
| mem_rdata | input | 16 | Read word (combinational) |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| sp | output | 16 | Stack pointer |
| pc_we | output | 1 | New program counter valid |
| pc_out | output | 16 | New program counter |
| flags_we | output | 1 | Restored flags valid |
| flags_out | output | 16 | Restored flags word |
| done | output | 1 | Operation complete |

## Verification
The assertions assume that the issuer keeps `cmd_op`, `cmd_reg` and `cmd_imm` steady while `cmd_valid` waits for `cmd_ready`. They also assume that memory returns read data in the same cycle as `mem_ready`. The bench respects both. Its command task sets the fields once and holds them until the acceptance edge. Its memory answers combinationally from its own byte array while `mem_ready` is raised on a random pattern, so that wait cycles appear on every kind of beat. Commands are issued back to back without waiting for completion, so held commands during busy periods occur naturally.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam logic [3:0] OP_LDSP  = 4'd0;
  localparam logic [3:0] OP_CALLI = 4'd1;
  localparam logic [3:0] OP_CALLR = 4'd2;
  localparam logic [3:0] OP_RET   = 4'd3;
  localparam logic [3:0] OP_PUSH  = 4'd4;
  localparam logic [3:0] OP_POP   = 4'd5;
  localparam logic [3:0] OP_PUSHF = 4'd6;
  localparam logic [3:0] OP_POPF  = 4'd7;
  localparam logic [3:0] OP_PUSHA = 4'd8;
  localparam logic [3:0] OP_POPA  = 4'd9;

  // operation needs at least one memory beat
  function automatic logic op_has_mem(logic [3:0] op);
    return (op >= OP_CALLI) && (op <= OP_POPA);
  endfunction

  // operation writes memory and advances SP afterwards
  function automatic logic op_is_push(logic [3:0] op);
    return (op == OP_CALLI) || (op == OP_CALLR) || (op == OP_PUSH) ||
           (op == OP_PUSHF) || (op == OP_PUSHA);
  endfunction

  // operation moves a whole register file
  function automatic logic op_is_bulk(logic [3:0] op);
    return (op == OP_PUSHA) || (op == OP_POPA);
  endfunction
endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
#(
  parameter int NREG = 16,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic          mem_ready,
  output logic          busy,
  output logic          accept,
  output logic          beat,
  output logic          last,
  output logic [RW-1:0] idx,
  output logic [3:0]    op_q
);
  logic busy_q;

  assign busy   = busy_q;
  assign accept = cmd_valid && !busy_q;
  assign beat   = busy_q && mem_ready;
  assign last   = op_is_bulk(op_q) ? (idx == RW'(NREG - 1)) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx    <= '0;
      op_q   <= OP_LDSP;
    end else if (accept) begin
      busy_q <= op_has_mem(cmd_op);
      idx    <= '0;
      op_q   <= cmd_op;
    end else if (beat) begin
      if (last) busy_q <= 1'b0;
      else      idx    <= idx + 1'b1;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !mem_ready |=> busy_q) else $error("request dropped"); // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !accept) else $error("accept while busy"); // R10
  AST_BULK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !last |=> busy_q && (idx == $past(idx) + 1'b1)) else $error("bulk index"); // R7
endmodule

// File: rtl/stack_seq_ptr.sv
module stack_seq_ptr
  import stack_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [3:0]    cmd_op,
  input  logic [DW-1:0] cmd_imm,
  input  logic          busy,
  input  logic          beat,
  input  logic          last,
  input  logic [3:0]    op_q,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] addr
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);
  localparam logic [DW-1:0] BLK  = DW'(NREG * (DW / 8));

  logic [DW-1:0] sp_q, ptr_q;

  assign sp   = sp_q;
  assign addr = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= '0;
      ptr_q <= '0;
    end else if (accept) begin
      case (cmd_op)
        OP_LDSP: sp_q <= cmd_imm;
        OP_RET, OP_POP, OP_POPF: begin
          sp_q  <= sp_q - STEP;
          ptr_q <= sp_q - STEP;
        end
        OP_POPA: begin
          sp_q  <= sp_q - BLK;
          ptr_q <= sp_q - BLK;
        end
        default: ptr_q <= sp_q;
      endcase
    end else if (beat) begin
      ptr_q <= ptr_q + STEP;
      if (last && op_is_push(op_q)) sp_q <= ptr_q + STEP;
    end
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !beat |=> $stable(addr)) else $error("address moved"); // R9
  AST_LDSP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_op == OP_LDSP |=> sp == $past(cmd_imm)) else $error("sp load"); // R2
  AST_POPALL_SP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_op == OP_POPA |=> sp == $past(sp) - BLK) else $error("popall sp"); // R8
  AST_SP_IDLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !beat |=> $stable(sp)) else $error("sp moved while waiting"); // R12
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int DW     = 16,
  parameter int NREG   = 16,
  parameter int PC_INC = 4,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [3:0]    cmd_op,
  input  logic [RW-1:0] cmd_reg,
  input  logic [DW-1:0] cmd_imm,
  input  logic [DW-1:0] cmd_pc,
  input  logic [DW-1:0] flags_in,
  output logic [RW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic [DW-1:0] sp,
  output logic          pc_we,
  output logic [DW-1:0] pc_out,
  output logic          flags_we,
  output logic [DW-1:0] flags_out,
  output logic          done
);
  logic          busy, accept, beat, last;
  logic [RW-1:0] idx, reg_q;
  logic [3:0]    op_q;
  logic [DW-1:0] data_q, tgt_q;

  stack_seq_ctrl #(.NREG(NREG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .mem_ready(mem_ready), .busy(busy), .accept(accept), .beat(beat),
    .last(last), .idx(idx), .op_q(op_q)
  );

  stack_seq_ptr #(.DW(DW), .NREG(NREG)) u_ptr (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_op(cmd_op),
    .cmd_imm(cmd_imm), .busy(busy), .beat(beat), .last(last), .op_q(op_q),
    .sp(sp), .addr(mem_addr)
  );

  // operand capture at acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      tgt_q  <= '0;
      reg_q  <= '0;
    end else if (accept) begin
      reg_q <= cmd_reg;
      case (cmd_op)
        OP_CALLI: begin data_q <= cmd_pc + DW'(PC_INC); tgt_q <= cmd_imm;  end
        OP_CALLR: begin data_q <= cmd_pc + DW'(PC_INC); tgt_q <= rf_rdata; end
        OP_PUSH:  data_q <= rf_rdata;
        OP_PUSHF: data_q <= flags_in;
        default:  ;
      endcase
    end
  end

  assign cmd_ready = !busy;
  assign rf_raddr  = busy ? idx : cmd_reg;
  assign mem_req   = busy;
  assign mem_we    = busy && op_is_push(op_q);
  assign mem_wdata = (op_q == OP_PUSHA) ? rf_rdata : data_q;

  assign rf_we     = beat && ((op_q == OP_POP) || (op_q == OP_POPA));
  assign rf_waddr  = (op_q == OP_POPA) ? idx : reg_q;
  assign rf_wdata  = mem_rdata;

  assign pc_we     = beat && ((op_q == OP_CALLI) || (op_q == OP_CALLR) || (op_q == OP_RET));
  assign pc_out    = (op_q == OP_RET) ? mem_rdata : tgt_q;

  assign flags_we  = beat && (op_q == OP_POPF);
  assign flags_out = mem_rdata;

  assign done = (beat && last) || (accept && !op_has_mem(cmd_op));

  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> $stable(mem_wdata) && $stable(mem_we)) else $error("wdata moved"); // R9
  AST_PC_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> mem_req && mem_ready) else $error("pc strobe outside beat"); // R11
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, pc_we, flags_we})) else $error("strobes overlap"); // R11
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req) else $error("ready while requesting"); // R10
endmodule

// File: tb/tb_stack_seq.sv
module tb_stack_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [3:0]  cmd_op = '0, cmd_reg = '0;
  logic [15:0] cmd_imm = '0, cmd_pc = '0, flags_in = '0;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata;
  logic        rf_we, mem_req, mem_we, mem_ready = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, sp, pc_out, flags_out;
  logic        pc_we, flags_we, done;

  always #2 clk = ~clk;

  stack_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_imm(cmd_imm), .cmd_pc(cmd_pc),
    .flags_in(flags_in), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .sp(sp), .pc_we(pc_we), .pc_out(pc_out), .flags_we(flags_we),
    .flags_out(flags_out), .done(done)
  );

  // surroundings: register file and little-endian byte memory
  logic [15:0] rf [16];
  logic [7:0]  bmem [512];
  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = {bmem[{mem_addr[8:1], 1'b1}], bmem[{mem_addr[8:1], 1'b0}]};

  always @(posedge clk) begin
    if (mem_req && mem_ready && mem_we) begin
      bmem[{mem_addr[8:1], 1'b0}] <= mem_wdata[7:0];
      bmem[{mem_addr[8:1], 1'b1}] <= mem_wdata[15:8];
    end
    if (rf_we) rf[rf_waddr] <= rf_wdata;
  end

  always @(posedge clk) begin
    #1 mem_ready <= ($urandom % 3) != 0;
  end

  // reference model
  typedef struct {
    bit we; logic [15:0] addr; logic [15:0] wdata;
    bit rfw; int ridx; bit pcw; logic [15:0] pcv;
    bit flw; logic [15:0] rval; bit last; string req;
  } beat_t;
  beat_t expq[$];
  logic [15:0] mmem [256];
  logic [15:0] mrf [16];
  logic [15:0] msp;
  string last_req = "R1";
  int nchk = 0, nfail = 0;
  bit run = 1'b0;
  bit wait_prev = 1'b0;
  logic [15:0] prev_addr, prev_wdata;
  bit prev_we;

  task automatic chk(bit ok, string req, string what, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic beat_t mk(bit we, logic [15:0] a, logic [15:0] wd, bit last, string req);
    beat_t b;
    b.we = we; b.addr = a; b.wdata = wd; b.rfw = 0; b.ridx = 0; b.pcw = 0;
    b.pcv = '0; b.flw = 0; b.rval = '0; b.last = last; b.req = req;
    return b;
  endfunction

  task automatic issue(logic [3:0] op, int r, logic [15:0] imm, logic [15:0] pc,
                       logic [15:0] fl, string req);
    beat_t b;
    case (op)
      4'd0: msp = imm;
      4'd1, 4'd2: begin
        b = mk(1, msp, pc + 16'd4, 1, req);
        b.pcw = 1; b.pcv = (op == 4'd1) ? imm : mrf[r];
        mmem[msp[8:1]] = pc + 16'd4; msp = msp + 16'd2; expq.push_back(b);
      end
      4'd3: begin
        msp = msp - 16'd2; b = mk(0, msp, '0, 1, req);
        b.pcw = 1; b.pcv = mmem[msp[8:1]]; expq.push_back(b);
      end
      4'd4: begin
        b = mk(1, msp, mrf[r], 1, req);
        mmem[msp[8:1]] = mrf[r]; msp = msp + 16'd2; expq.push_back(b);
      end
      4'd5: begin
        msp = msp - 16'd2; b = mk(0, msp, '0, 1, req);
        b.rfw = 1; b.ridx = r; b.rval = mmem[msp[8:1]]; mrf[r] = b.rval;
        expq.push_back(b);
      end
      4'd6: begin
        b = mk(1, msp, fl, 1, req);
        mmem[msp[8:1]] = fl; msp = msp + 16'd2; expq.push_back(b);
      end
      4'd7: begin
        msp = msp - 16'd2; b = mk(0, msp, '0, 1, req);
        b.flw = 1; b.rval = mmem[msp[8:1]]; expq.push_back(b);
      end
      4'd8: begin
        for (int i = 0; i < 16; i++) begin
          b = mk(1, msp, mrf[i], i == 15, req);
          mmem[msp[8:1]] = mrf[i]; msp = msp + 16'd2; expq.push_back(b);
        end
      end
      4'd9: begin
        msp = msp - 16'd32;
        for (int i = 0; i < 16; i++) begin
          logic [15:0] a;
          a = msp + 16'(2 * i);
          b = mk(0, a, '0, i == 15, req);
          b.rfw = 1; b.ridx = i; b.rval = mmem[a[8:1]]; mrf[i] = b.rval;
          expq.push_back(b);
        end
      end
      default: ;
    endcase
    last_req = req;
    cmd_op = op; cmd_reg = 4'(r); cmd_imm = imm; cmd_pc = pc; flags_in = fl;
    cmd_valid = 1'b1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  // per-clock comparison
  always @(negedge clk) begin
    if (run) begin
      bit exp_done;
      chk(!(cmd_ready && mem_req), "R10", "ready while busy", {15'd0, cmd_ready}, 16'd0);
      if (wait_prev) begin
        chk(mem_req && mem_addr == prev_addr && mem_we == prev_we &&
            (!prev_we || mem_wdata == prev_wdata), "R9", "held beat", mem_addr, prev_addr);
      end
      wait_prev = mem_req && !mem_ready;
      prev_addr = mem_addr; prev_we = mem_we; prev_wdata = mem_wdata;
      if (mem_req && mem_ready) begin
        if (expq.size() == 0) chk(0, "R11", "unexpected beat", mem_addr, 16'd0);
        else begin
          beat_t b;
          b = expq.pop_front();
          chk(mem_addr == b.addr, b.req, "address", mem_addr, b.addr);
          chk(mem_we == b.we, b.req, "direction", {15'd0, mem_we}, {15'd0, b.we});
          if (b.we) chk(mem_wdata == b.wdata, b.req, "write data", mem_wdata, b.wdata);
          chk(rf_we == b.rfw, "R11", "rf_we", {15'd0, rf_we}, {15'd0, b.rfw});
          if (b.rfw) begin
            chk(rf_waddr == 4'(b.ridx), b.req, "rf addr", {12'd0, rf_waddr}, 16'(b.ridx));
            chk(rf_wdata == b.rval, b.req, "rf data", rf_wdata, b.rval);
          end
          chk(pc_we == b.pcw, "R11", "pc_we", {15'd0, pc_we}, {15'd0, b.pcw});
          if (b.pcw) chk(pc_out == b.pcv, b.req, "pc", pc_out, b.pcv);
          chk(flags_we == b.flw, "R11", "flags_we", {15'd0, flags_we}, {15'd0, b.flw});
          if (b.flw) chk(flags_out == b.rval, b.req, "flags", flags_out, b.rval);
          chk(done == b.last, "R11", "done at beat", {15'd0, done}, {15'd0, b.last});
        end
      end else begin
        exp_done = cmd_valid && cmd_ready && (cmd_op == 4'd0 || cmd_op >= 4'd10);
        chk(!rf_we && !pc_we && !flags_we, "R11", "strobe outside beat",
            {13'd0, rf_we, pc_we, flags_we}, 16'd0);
        chk(done == exp_done, (cmd_op >= 4'd10) ? "R13" : "R2", "done without beat",
            {15'd0, done}, {15'd0, exp_done});
      end
      if (cmd_ready && !cmd_valid && expq.size() == 0)
        chk(sp == msp, last_req, "sp", sp, msp);
    end
  end

  initial begin
    #600000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) bmem[i] = 8'h00;
    for (int i = 0; i < 256; i++) mmem[i] = 16'h0000;
    for (int i = 0; i < 16; i++) begin
      rf[i]  = 16'h1000 + 16'(i * 16'h0111);
      mrf[i] = rf[i];
    end
    msp = 16'h0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(sp == 16'h0000, "R1", "reset sp", sp, 16'h0000);
    chk(cmd_ready && !mem_req && !done, "R1", "reset controls",
        {13'd0, cmd_ready, mem_req, done}, 16'h0004);
    run = 1'b1;
    @(posedge clk); #1;

    issue(4'd0, 0, 16'h0100, 16'h0, 16'h0, "R2");
    issue(4'd4, 3, 16'h0, 16'h0, 16'h0, "R5");
    issue(4'd4, 7, 16'h0, 16'h0, 16'h0, "R5");
    issue(4'd5, 9, 16'h0, 16'h0, 16'h0, "R5");
    issue(4'd5, 2, 16'h0, 16'h0, 16'h0, "R5");
    issue(4'd6, 0, 16'h0, 16'h0, 16'hA5C3, "R6");
    issue(4'd7, 0, 16'h0, 16'h0, 16'h0, "R6");
    issue(4'd1, 0, 16'h0200, 16'h0040, 16'h0, "R3");
    issue(4'd2, 5, 16'h0, 16'h0300, 16'h0, "R3");
    issue(4'd3, 0, 16'h0, 16'h0, 16'h0, "R4");
    issue(4'd3, 0, 16'h0, 16'h0, 16'h0, "R4");
    issue(4'd8, 0, 16'h0, 16'h0, 16'h0, "R7");
    issue(4'd5, 4, 16'h0, 16'h0, 16'h0, "R5");
    issue(4'd4, 0, 16'h0, 16'h0, 16'h0, "R5");
    issue(4'd9, 0, 16'h0, 16'h0, 16'h0, "R8");
    issue(4'd11, 0, 16'h1234, 16'h0, 16'h0, "R13");
    issue(4'd15, 0, 16'h0, 16'h0, 16'h0, "R13");
    issue(4'd0, 0, 16'hFFFE, 16'h0, 16'h0, "R12");
    issue(4'd4, 1, 16'h0, 16'h0, 16'h0, "R12");
    issue(4'd5, 6, 16'h0, 16'h0, 16'h0, "R12");
    issue(4'd0, 0, 16'h0010, 16'h0, 16'h0, "R12");
    issue(4'd9, 0, 16'h0, 16'h0, 16'h0, "R12");
    issue(4'd8, 0, 16'h0, 16'h0, 16'h0, "R12");

    while (expq.size() != 0 || !cmd_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++)
      chk(rf[i] == mrf[i], "R8", "final register", rf[i], mrf[i]);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule